// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block controls a behavioural one-time-programmable fuse store of 64 words of 32 bits. Each even/odd pair of words holds one logical word and its shadow copy, and a program operation writes both words of the pair together, so the two stay equal. Bits can only be set: a program ORs its data into the pair, and no operation returns a bit to 0.

Software reaches the block through a simple 32-bit register bus. It sets an address, write data and a pulse length, then writes a command code into the control register. A sequencer runs the command and shows a state field that reads 4 while idle. Software polls that field before and after each command. A sense operation copies the whole store into a sense latch. Reads return the latched copy, not the live store. A program proceeds only when the software power-good bit is 1, the write-access lock is open and the external program-disable input is low. Otherwise the program is dropped and the store is left as it was.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control register reads 0x0004_0000. The write-access register (0x030) reads 1, the power-good register (0x034) reads 0 and the read-data register (0x008) reads 0.
- R2: Control bits [1:0] written at 0x000 select the command: 1 = read, 2 = program, 3 = sense. Code 0 starts nothing. Control bits [19:16] report state, with 4 for idle and any other value for busy.
- R3: A read or a sense keeps the state busy for 4 cycles. A permitted program is busy for the pulse-time value (0x01C bits [15:0]) plus 2 cycles. A refused program is busy for 1 cycle.
- R4: A program ORs the write data (0x00C) into both words of the pair that holds address bits [5:0] (pair = address >> 1). No fuse bit is ever cleared.
- R5: A read loads register 0x008 with the addressed word as it stood in the sense latch. Before any sense this value is 0, and a program does not show in reads until the next sense.
- R6: A program is refused when 0x034 bit 0 is 0, when 0x030 bit 0 is 1, or when the program-disable input is 1. A refused program leaves the store unchanged. Register 0x02C bit 0 reports the program-disable input.
- R7: Control bit 30 goes to 1 when a sense completes. It clears when the next sense starts.
- R8: A command written while the state is busy is ignored. This includes a command written in the cycle in which the current command finishes.
- R9: Writing 1 to bit 0 of register 0x020 starts a sense, the same as sense command code 3.
- R10: The address (0x004, bits [5:0]), the write data (0x00C) and the pulse time (0x01C, bits [15:0]) read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| pgm_disable_i | input | 1 | Program-disable status; 1 blocks programming |

## Verification
Two events can land on the same clock edge: a command finishing and a new command being written. The bench provokes this by counting the cycles of a read and writing a program command so that it meets the read's final edge. The program must be dropped. The state must read idle on the next cycle, and a later sense and read of the target word must still show no change. A second case writes a command while a read is in its first busy cycle. The read's remaining busy length and the untouched target word show that the command was ignored.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_ADDR  = 8'h04;
  localparam logic [7:0] OFS_RDAT  = 8'h08;
  localparam logic [7:0] OFS_WDAT  = 8'h0C;
  localparam logic [7:0] OFS_PULSE = 8'h1C;
  localparam logic [7:0] OFS_TRIG  = 8'h20;
  localparam logic [7:0] OFS_DIS   = 8'h2C;
  localparam logic [7:0] OFS_LOCK  = 8'h30;
  localparam logic [7:0] OFS_PWR   = 8'h34;

  localparam logic [1:0] CMD_NONE  = 2'd0;
  localparam logic [1:0] CMD_READ  = 2'd1;
  localparam logic [1:0] CMD_PROG  = 2'd2;
  localparam logic [1:0] CMD_SENSE = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd4,
    ST_READ  = 4'd5,
    ST_PROG  = 4'd6,
    ST_SENSE = 4'd7
  } otp_state_e;
endpackage

// File: rtl/otp_fuse_store.sv
module otp_fuse_store #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  localparam int PAIR_W = $clog2(WORDS / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_en_i,
  input  logic [PAIR_W-1:0] pgm_pair_i,
  input  logic [DATA_W-1:0] pgm_data_i,
  output logic [DATA_W-1:0] words_o [WORDS]
);
  logic [DATA_W-1:0] words_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = pgm_en_i && (pgm_pair_i == PAIR_W'(w / 2));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[w] <= '0;
      end else if (hit) begin
        words_q[w] <= words_q[w] | pgm_data_i;
      end
    end

    p_bits_stay_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(words_q[w]) & ~words_q[w]) == '0))
      else $error("fuse bit cleared in word %0d", w);

    assign words_o[w] = words_q[w];
  end
endmodule

// File: rtl/otp_sense_latch.sv
module otp_sense_latch #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] words_i [WORDS],
  input  logic [IDX_W-1:0]  sel_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] held_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_held
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q[w] <= '0;
      end else if (cap_en_i) begin
        held_q[w] <= words_i[w];
      end
    end
  end

  assign word_o = held_q[sel_i];
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_pkg::*;
#(
  parameter int PULSE_W = 16,
  parameter int FIX_LEN = 4,
  localparam int CNT_W  = PULSE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         cmd_i,
  input  logic               perm_i,
  input  logic [PULSE_W-1:0] pulse_i,
  output otp_state_e         state_o,
  output logic               read_fire_o,
  output logic               prog_fire_o,
  output logic               sense_fire_o,
  output logic               sense_start_o
);
  otp_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic perm_q, perm_d;
  logic accept, finish;

  assign accept = start_i && (st_q == ST_IDLE) && (cmd_i != CMD_NONE);
  assign finish = (st_q != ST_IDLE) && (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    perm_d = perm_q;
    if (accept) begin
      unique case (cmd_i)
        CMD_READ: begin
          st_d  = ST_READ;
          cnt_d = CNT_W'(FIX_LEN - 1);
        end
        CMD_PROG: begin
          st_d   = ST_PROG;
          perm_d = perm_i;
          cnt_d  = perm_i ? ({1'b0, pulse_i} + CNT_W'(1)) : '0;
        end
        default: begin
          st_d  = ST_SENSE;
          cnt_d = CNT_W'(FIX_LEN - 1);
        end
      endcase
    end else if (finish) begin
      st_d = ST_IDLE;
    end else if (st_q != ST_IDLE) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      perm_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      perm_q <= perm_d;
    end
  end

  assign state_o       = st_q;
  assign read_fire_o   = finish && (st_q == ST_READ);
  assign prog_fire_o   = finish && (st_q == ST_PROG) && perm_q;
  assign sense_fire_o  = finish && (st_q == ST_SENSE);
  assign sense_start_o = accept && (cmd_i == CMD_SENSE);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && cnt_q != '0) |=> (st_q == $past(st_q)))
    else $error("busy state changed before its count ran out");

  p_end_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && cnt_q == '0) |=> (st_q == ST_IDLE))
    else $error("command did not return to idle at count end");
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int WORDS   = 64,
  parameter int DATA_W  = 32,
  parameter int PULSE_W = 16,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int PAIR_W = $clog2(WORDS / 2)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        pgm_disable_i
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [IDX_W-1:0]   addr_q;
  logic [DATA_W-1:0]  wdat_q, rdat_q;
  logic [PULSE_W-1:0] pulse_q;
  logic               lock_q, pwr_q, sdone_q;

  logic we_addr, we_wdat, we_pulse, we_lock, we_pwr, we_ctrl, we_trig;
  assign we_ctrl  = bus_wr_en && (bus_addr == OFS_CTRL);
  assign we_addr  = bus_wr_en && (bus_addr == OFS_ADDR);
  assign we_wdat  = bus_wr_en && (bus_addr == OFS_WDAT);
  assign we_pulse = bus_wr_en && (bus_addr == OFS_PULSE);
  assign we_trig  = bus_wr_en && (bus_addr == OFS_TRIG) && bus_wdata[0];
  assign we_lock  = bus_wr_en && (bus_addr == OFS_LOCK);
  assign we_pwr   = bus_wr_en && (bus_addr == OFS_PWR);

  logic       start;
  logic [1:0] cmd;
  logic       perm;
  assign start = we_ctrl || we_trig;
  assign cmd   = we_trig ? CMD_SENSE : bus_wdata[1:0];
  assign perm  = pwr_q && !lock_q && !pgm_disable_i;

  otp_state_e state;
  logic read_fire, prog_fire, sense_fire, sense_start;

  otp_cmd_seq #(.PULSE_W(PULSE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .start_i       (start),
    .cmd_i         (cmd),
    .perm_i        (perm),
    .pulse_i       (pulse_q),
    .state_o       (state),
    .read_fire_o   (read_fire),
    .prog_fire_o   (prog_fire),
    .sense_fire_o  (sense_fire),
    .sense_start_o (sense_start)
  );

  logic [DATA_W-1:0] live_words [WORDS];
  logic [DATA_W-1:0] held_word;

  otp_fuse_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .pgm_en_i   (prog_fire),
    .pgm_pair_i (addr_q[IDX_W-1 -: PAIR_W]),
    .pgm_data_i (wdat_q),
    .words_o    (live_words)
  );

  otp_sense_latch #(.WORDS(WORDS), .DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cap_en_i (sense_fire),
    .words_i  (live_words),
    .sel_i    (addr_q),
    .word_o   (held_word)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q  <= '0;
      wdat_q  <= '0;
      pulse_q <= '0;
      lock_q  <= 1'b1;
      pwr_q   <= 1'b0;
    end else begin
      if (we_addr)  addr_q  <= bus_wdata[IDX_W-1:0];
      if (we_wdat)  wdat_q  <= bus_wdata[DATA_W-1:0];
      if (we_pulse) pulse_q <= bus_wdata[PULSE_W-1:0];
      if (we_lock)  lock_q  <= bus_wdata[0];
      if (we_pwr)   pwr_q   <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdat_q  <= '0;
      sdone_q <= 1'b0;
    end else begin
      if (read_fire)        rdat_q  <= held_word;
      if (sense_start)      sdone_q <= 1'b0;
      else if (sense_fire)  sdone_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[30]    = sdone_q;
        bus_rdata[19:16] = state;
      end
      OFS_ADDR:  bus_rdata[IDX_W-1:0]   = addr_q;
      OFS_RDAT:  bus_rdata[DATA_W-1:0]  = rdat_q;
      OFS_WDAT:  bus_rdata[DATA_W-1:0]  = wdat_q;
      OFS_PULSE: bus_rdata[PULSE_W-1:0] = pulse_q;
      OFS_DIS:   bus_rdata[0]           = pgm_disable_i;
      OFS_LOCK:  bus_rdata[0]           = lock_q;
      OFS_PWR:   bus_rdata[0]           = pwr_q;
      default:   bus_rdata = '0;
    endcase
  end

  p_sense_done_low_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state == ST_SENSE) |-> !sdone_q)
    else $error("sense-done flag high during a sense");
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module tb_otp_fuse_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pgm_disable_i;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  otp_fuse_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pgm_disable_i(pgm_disable_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic busy_len(output int n);
    n = 0; bus_addr = 8'h00; #1;
    while (bus_rdata[19:16] != 4'd4 && n < 100000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  task automatic do_cmd(input logic [1:0] c, output int n);
    wr(8'h00, {30'd0, c});
    busy_len(n);
  endtask

  task automatic sense_read(input logic [5:0] a, output logic [31:0] v);
    int n;
    wr(8'h04, {26'd0, a});
    do_cmd(2'd3, n);
    do_cmd(2'd1, n);
    rd(8'h08, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 R2 ctrl idle", v, 32'h0004_0000);
    rd(8'h30, v); chk("R1 lock", v, 32'd1);
    rd(8'h34, v); chk("R1 power-good", v, 32'd0);
    rd(8'h08, v); chk("R1 read data", v, 32'd0);
  endtask

  task automatic t_read_before_sense;
    int n; logic [31:0] v;
    wr(8'h04, 32'd5);
    do_cmd(2'd1, n); chk("R3 read length", n, 4);
    rd(8'h08, v); chk("R5 read before sense", v, 32'd0);
  endtask

  task automatic t_program;
    int n; logic [31:0] v;
    wr(8'h34, 32'd1); wr(8'h30, 32'd0); wr(8'h1C, 32'd10);
    wr(8'h04, 32'd6); wr(8'h0C, 32'h0000_00F0);
    do_cmd(2'd2, n); chk("R3 program length pulse 10", n, 12);
    do_cmd(2'd1, n); rd(8'h08, v); chk("R5 program hidden until sense", v, 32'd0);
    do_cmd(2'd3, n); chk("R3 sense length", n, 4);
    rd(8'h00, v); chk("R7 sense done set", v[30], 32'd1);
    sense_read(6'd6, v); chk("R4 word 6", v, 32'h0000_00F0);
    sense_read(6'd7, v); chk("R4 shadow word 7", v, 32'h0000_00F0);
    wr(8'h0C, 32'h0F00_0001); wr(8'h1C, 32'd0);
    do_cmd(2'd2, n); chk("R3 program length pulse 0", n, 2);
    wr(8'h0C, 32'd0);
    do_cmd(2'd2, n);
    sense_read(6'd6, v); chk("R4 OR into pair, zero keeps bits", v, 32'h0F00_00F1);
  endtask

  task automatic t_reject;
    int n; logic [31:0] v;
    wr(8'h0C, 32'hFFFF_0000); wr(8'h04, 32'd6);
    wr(8'h34, 32'd0);
    do_cmd(2'd2, n); chk("R6 R3 no power-good length", n, 1);
    wr(8'h34, 32'd1); wr(8'h30, 32'd1);
    do_cmd(2'd2, n); chk("R6 R3 locked length", n, 1);
    wr(8'h30, 32'd0); pgm_disable_i = 1'b1;
    do_cmd(2'd2, n); chk("R6 R3 disabled length", n, 1);
    rd(8'h2C, v); chk("R6 disable status", v, 32'd1);
    pgm_disable_i = 1'b0;
    sense_read(6'd6, v); chk("R6 store unchanged", v, 32'h0F00_00F1);
  endtask

  task automatic t_trigger;
    int n; logic [31:0] v;
    wr(8'h20, 32'd1);
    rd(8'h00, v); chk("R7 done cleared at sense start", v[30], 32'd0);
    chk("R9 trigger starts busy", {28'd0, v[19:16]}, 32'd7);
    busy_len(n); chk("R9 trigger sense length", n, 4);
    rd(8'h00, v); chk("R9 R7 done after trigger", v[30], 32'd1);
  endtask

  task automatic t_busy_ignore;
    int n; logic [31:0] v;
    wr(8'h04, 32'd8); wr(8'h0C, 32'hAAAA_5555); wr(8'h1C, 32'd20);
    wr(8'h00, 32'd1);
    wr(8'h00, 32'd2);
    busy_len(n); chk("R8 read kept its length", n, 3);
    sense_read(6'd8, v); chk("R8 program during busy ignored", v, 32'd0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    wr(8'h00, 32'd1);
    repeat (3) @(negedge clk);
    wr(8'h00, 32'd2);
    rd(8'h00, v); chk("R8 command on finish edge dropped", {28'd0, v[19:16]}, 32'd4);
    wr(8'h00, 32'd0);
    rd(8'h00, v); chk("R2 code 0 starts nothing", {28'd0, v[19:16]}, 32'd4);
    sense_read(6'd9, v); chk("R8 collided program left store", v, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    rd(8'h04, v); chk("R10 address readback", v, 32'd9);
    rd(8'h0C, v); chk("R10 write data readback", v, 32'hAAAA_5555);
    rd(8'h1C, v); chk("R10 pulse readback", v, 32'd20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    pgm_disable_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_read_before_sense;
    t_program;
    t_reject;
    t_trigger;
    t_busy_ignore;
    t_collision;
    t_regs;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule